// File: doc/BRIEF.md
# Data Address Watchpoint Match Unit

This block is a debug comparator for the load/store path of a 64-bit core. It holds two independent watchpoint channels. Each channel has a base-address register and a control register, and both are loaded through a special-purpose-register write port. Every data access presents its effective address, its byte count, its direction and the current processor mode: user (problem) state, hypervisor state and data translation. Each channel then reports whether the access touched its watched region under the filters programmed for it.

A channel watches a doubleword-aligned region of 1 to 64 doublewords. A hit is allowed only when all of these hold: the access direction is enabled, the current privilege level is enabled, and the translation filter passes. The translation filter either compares the data-translation bit with a programmed value or is switched off. The per-channel hit flags and a combined debug request are registered, so they appear one cycle after the access. Exception delivery, capture of the faulting address and any address-mirroring option are left to the surrounding core.

Top module: `dwatch_unit`

## Requirements
- R1: After reset both registers of every channel are zero, `hit_o` and `dbg_req_o` are 0, and no access hits.
- R2: Register number 0xB4 + c loads channel c's address register and 0xBC + c loads its control register, for c = 0 or 1. A write to any other number changes no channel.
- R3: The region base is the address register with bits [2:0] forced to zero (LSB-0 numbering), so it always starts on an 8-byte boundary.
- R4: Control bits [15:10] hold a range value n, and the region spans n+1 doublewords starting at the base. An access covers bytes ea_i to ea_i + size_i, so `size_i` is the byte count minus 1. The access hits when any of those bytes lies in the region, including an access that crosses either edge of the region.
- R5: Control bit 6 enables writes and control bit 5 enables reads (`is_write_i` = 1 marks a write). With both bits clear the channel never hits.
- R6: When control bit 3 (ignore translation) is clear, a hit needs `dr_i` to equal control bit 4. When bit 3 is set, `dr_i` is not checked.
- R7: Control bit 0 enables user state (`pr_i` = 1), bit 2 enables hypervisor state (`pr_i` = 0, `hv_i` = 1) and bit 1 enables supervisor state (`pr_i` = 0, `hv_i` = 0). An access made in a state whose bit is clear never hits.
- R8: Control bit 7 (address-mirroring select) is not supported, and setting it changes no hit result.
- R9: `hit_o[c]` reflects the access presented in the previous cycle. A register write is used by accesses from the next cycle onward, and an access in the same cycle as the write still uses the old value.
- R10: Channels match independently. `dbg_req_o` is the OR of `hit_o` in every cycle.
- R11: A cycle with `acc_valid_i` low produces no hit in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_we_i | input | 1 | Register write strobe |
| spr_num_i | input | 10 | Register number |
| spr_wdata_i | input | 64 | Register write data |
| acc_valid_i | input | 1 | A data access is presented this cycle |
| ea_i | input | 64 | Effective address of the access |
| size_i | input | 4 | Byte count of the access minus 1 |
| is_write_i | input | 1 | 1 for a store, 0 for a load |
| pr_i | input | 1 | User (problem) state |
| hv_i | input | 1 | Hypervisor state |
| dr_i | input | 1 | Data translation enabled |
| hit_o | output | 2 | Registered per-channel hit flags |
| dbg_req_o | output | 1 | Registered combined debug request |

## Verification
On every cycle, the assertions check the gating rules that forbid a hit. These are an idle cycle, a channel with both direction enables clear, a user-state access without the user enable, and a failed translation compare. They also check that the combined request always equals the OR of the channel flags. The bench scenarios are the only place that shows a hit does occur where it should. They cover the exact byte extent of the region at both edges and at the largest range, accesses that straddle an edge, the base bits that are ignored, register-number decode, the mirroring bit having no effect, and the one-cycle visibility of register writes.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  // register numbers; channel index is added to the base
  localparam int unsigned ADDR_REG_BASE = 'hB4;
  localparam int unsigned CTRL_REG_BASE = 'hBC;

  // control field positions (LSB-0)
  localparam int unsigned RANGE_LSB = 10;
  localparam int unsigned WR_BIT    = 6;
  localparam int unsigned RD_BIT    = 5;
  localparam int unsigned XV_BIT    = 4;
  localparam int unsigned XI_BIT    = 3;
  localparam int unsigned HV_BIT    = 2;
  localparam int unsigned SV_BIT    = 1;
  localparam int unsigned PR_BIT    = 0;

  typedef struct packed {
    logic wr_en;
    logic rd_en;
    logic xl_val;
    logic xl_ign;
    logic hyp_en;
    logic sup_en;
    logic usr_en;
  } wp_ctrl_t;

  // user state takes precedence over hypervisor
  function automatic logic priv_ok(wp_ctrl_t c, logic pr, logic hv);
    if (pr)      return c.usr_en;
    else if (hv) return c.hyp_en;
    else         return c.sup_en;
  endfunction
endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
  import dwatch_pkg::*;
#(
  parameter int          DATA_W  = 64,
  parameter int          NUM_W   = 10,
  parameter int          RANGE_W = 6,
  parameter int unsigned CH      = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_W-1:0]     num_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-4:0]    base_dw_o,
  output logic [RANGE_W-1:0]   range_o,
  output wp_ctrl_t             ctrl_o
);
  localparam logic [NUM_W-1:0] ADDR_NUM = NUM_W'(ADDR_REG_BASE + CH);
  localparam logic [NUM_W-1:0] CTRL_NUM = NUM_W'(CTRL_REG_BASE + CH);

  logic addr_sel, ctrl_sel;
  assign addr_sel = we_i && (num_i == ADDR_NUM);
  assign ctrl_sel = we_i && (num_i == CTRL_NUM);

  // only the decoded fields are kept; mirroring select and spare bits are dropped
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:RANGE_LSB+RANGE_W], wdata_i[RANGE_LSB-1:WR_BIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_dw_o <= '0;
      range_o   <= '0;
      ctrl_o    <= '0;
    end else begin
      if (addr_sel) base_dw_o <= wdata_i[DATA_W-1:3];
      if (ctrl_sel) begin
        range_o       <= wdata_i[RANGE_LSB +: RANGE_W];
        ctrl_o.wr_en  <= wdata_i[WR_BIT];
        ctrl_o.rd_en  <= wdata_i[RD_BIT];
        ctrl_o.xl_val <= wdata_i[XV_BIT];
        ctrl_o.xl_ign <= wdata_i[XI_BIT];
        ctrl_o.hyp_en <= wdata_i[HV_BIT];
        ctrl_o.sup_en <= wdata_i[SV_BIT];
        ctrl_o.usr_en <= wdata_i[PR_BIT];
      end
    end
  end
endmodule

// File: rtl/dwatch_match.sv
module dwatch_match
  import dwatch_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SIZE_W  = 4,
  parameter int RANGE_W = 6
) (
  input  logic [ADDR_W-4:0]  base_dw_i,
  input  logic [RANGE_W-1:0] range_i,
  input  wp_ctrl_t           ctrl_i,
  input  logic [ADDR_W-1:0]  ea_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic               is_write_i,
  input  logic               pr_i,
  input  logic               hv_i,
  input  logic               dr_i,
  output logic               match_o
);
  localparam int DW_W = ADDR_W - 2;  // doubleword index plus carry bit

  logic [ADDR_W:0]   end_b;
  logic [DW_W-1:0]   first_dw, last_dw, lo_dw, hi_dw;
  logic              range_ok, dir_ok, xl_ok;

  // compare in doubleword units: first/last dword touched vs region bounds
  assign end_b    = {1'b0, ea_i} + (ADDR_W+1)'(size_i);
  assign first_dw = {1'b0, ea_i[ADDR_W-1:3]};
  assign last_dw  = end_b[ADDR_W:3];
  assign lo_dw    = {1'b0, base_dw_i};
  assign hi_dw    = lo_dw + DW_W'(range_i);
  assign range_ok = (first_dw <= hi_dw) && (last_dw >= lo_dw);

  assign dir_ok  = is_write_i ? ctrl_i.wr_en : ctrl_i.rd_en;
  assign xl_ok   = ctrl_i.xl_ign || (dr_i == ctrl_i.xl_val);
  assign match_o = range_ok && dir_ok && xl_ok && priv_ok(ctrl_i, pr_i, hv_i);
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int ADDR_W  = 64,
  parameter int NUM_W   = 10,
  parameter int SIZE_W  = 4,
  parameter int RANGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spr_we_i,
  input  logic [NUM_W-1:0]  spr_num_i,
  input  logic [ADDR_W-1:0] spr_wdata_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              is_write_i,
  input  logic              pr_i,
  input  logic              hv_i,
  input  logic              dr_i,
  output logic [NUM_CH-1:0] hit_o,
  output logic              dbg_req_o
);
  logic [NUM_CH-1:0] match_c;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-4:0]  base_dw;
    logic [RANGE_W-1:0] range;
    wp_ctrl_t           ctrl;

    dwatch_regs #(
      .DATA_W(ADDR_W), .NUM_W(NUM_W), .RANGE_W(RANGE_W), .CH(c)
    ) u_regs (
      .clk_i, .rst_ni,
      .we_i(spr_we_i), .num_i(spr_num_i), .wdata_i(spr_wdata_i),
      .base_dw_o(base_dw), .range_o(range), .ctrl_o(ctrl)
    );

    dwatch_match #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .RANGE_W(RANGE_W)
    ) u_match (
      .base_dw_i(base_dw), .range_i(range), .ctrl_i(ctrl),
      .ea_i, .size_i, .is_write_i, .pr_i, .hv_i, .dr_i,
      .match_o(match_c[c])
    );

    // R5
    a_r5_disabled_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl.wr_en && !ctrl.rd_en) |=> !hit_o[c]);
    // R7
    a_r7_user_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && pr_i && !ctrl.usr_en) |=> !hit_o[c]);
    // R6
    a_r6_xlate_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && !ctrl.xl_ign && (dr_i != ctrl.xl_val)) |=> !hit_o[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= '0;
      dbg_req_o <= 1'b0;
    end else begin
      hit_o     <= acc_valid_i ? match_c : '0;
      dbg_req_o <= acc_valid_i && (|match_c);
    end
  end

  // R11
  a_r11_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (hit_o == '0));
  // R10
  a_r10_req_is_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o == (|hit_o));
endmodule

// File: tb/dwatch_unit_tb_top.sv
`timescale 1ns/1ps
module dwatch_unit_tb_top;
  logic clk = 0, rst_ni = 0;
  logic spr_we = 0, acc_valid = 0, is_write = 0, pr = 0, hv = 0, dr = 0;
  logic [9:0] spr_num = '0;
  logic [63:0] spr_wdata = '0, ea = '0;
  logic [3:0] size = '0;
  logic [1:0] hit;
  logic dbg_req;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  dwatch_unit dut_i (
    .clk_i(clk), .rst_ni, .spr_we_i(spr_we), .spr_num_i(spr_num), .spr_wdata_i(spr_wdata),
    .acc_valid_i(acc_valid), .ea_i(ea), .size_i(size), .is_write_i(is_write),
    .pr_i(pr), .hv_i(hv), .dr_i(dr), .hit_o(hit), .dbg_req_o(dbg_req)
  );

  localparam logic [63:0] C_WR = 64'h40, C_RD = 64'h20, C_XV = 64'h10, C_XI = 64'h8;
  localparam logic [63:0] C_HV = 64'h4, C_SV = 64'h2, C_PR = 64'h1, C_MIR = 64'h80;
  localparam logic [63:0] C_ALL = C_WR | C_RD | C_XI | C_HV | C_SV | C_PR;
  function automatic logic [63:0] rng(int n); return 64'(n) << 10; endfunction

  logic [63:0] sh_addr [2];
  logic [63:0] sh_ctrl [2];

  typedef struct { logic [1:0] hit; logic dbg; string req; } exp_t;
  exp_t sbq[$];

  function automatic logic exp_hit(int c, logic [63:0] a, logic [3:0] sz, logic w, logic p, logic h, logic d);
    logic [63:0] ct;
    logic [65:0] base, lenb, lo, hi;
    logic en;
    ct = sh_ctrl[c];
    en = w ? ct[6] : ct[5];
    if (!ct[3] && d != ct[4]) en = 0;
    if (p) en = en & ct[0];
    else if (h) en = en & ct[2];
    else en = en & ct[1];
    base = {2'b0, sh_addr[c][63:3], 3'b0};
    lenb = ({60'b0, ct[15:10]} + 66'd1) * 66'd8;
    lo = {2'b0, a};
    hi = lo + {62'b0, sz} + 66'd1;
    return en && (lo < base + lenb) && (hi > base);
  endfunction

  task automatic step(logic we, logic [9:0] num, logic [63:0] wd, logic v, logic [63:0] a,
                      logic [3:0] sz, logic w, logic p, logic h, logic d, string req);
    exp_t e;
    for (int c = 0; c < 2; c++) e.hit[c] = v && exp_hit(c, a, sz, w, p, h, d);
    e.dbg = |e.hit;
    e.req = req;
    sbq.push_back(e);
    if (we) for (int c = 0; c < 2; c++) begin
      if (num == 10'(32'hB4 + c)) sh_addr[c] = wd;
      if (num == 10'(32'hBC + c)) sh_ctrl[c] = wd;
    end
    spr_we = we; spr_num = num; spr_wdata = wd;
    acc_valid = v; ea = a; size = sz; is_write = w; pr = p; hv = h; dr = d;
    @(negedge clk);
  endtask

  task automatic wreg(logic [9:0] num, logic [63:0] wd, string req);
    step(1, num, wd, 0, '0, '0, 0, 0, 0, 0, req);
  endtask

  task automatic acc(logic [63:0] a, logic [3:0] sz, logic w, logic p, logic h, logic d, string req);
    step(0, '0, '0, 1, a, sz, w, p, h, d, req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // monitor: one expected item per driven cycle, compared after the following edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        checks++;
        if (hit !== e.hit || dbg_req !== e.dbg) begin
          fails++;
          $display("FAIL %s: hit=%b dbg=%b expected hit=%b dbg=%b", e.req, hit, dbg_req, e.hit, e.dbg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin sh_addr[c] = '0; sh_ctrl[c] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== 2'b00 || dbg_req !== 1'b0) begin
      fails++;
      $display("FAIL R1: hit=%b dbg=%b expected hit=00 dbg=0", hit, dbg_req);
    end
    rst_ni = 1;
    @(negedge clk);
    // R1: zeroed registers never hit
    acc(64'h0, 4'd7, 1, 0, 0, 0, "R1");
    acc(64'h0, 4'd7, 0, 1, 0, 1, "R1");
    // R3: low address bits ignored
    wreg(10'hB4, 64'h1000_0005, "R3");
    // R9: control write and access in the same cycle use old control
    step(1, 10'hBC, rng(1) | C_ALL, 1, 64'h1000_0000, 4'd0, 1, 0, 0, 0, "R9");
    acc(64'h1000_0000, 4'd0, 1, 0, 0, 0, "R9");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 0, "R3");
    // R4: region edges and straddling
    acc(64'h1000_000F, 4'd0, 0, 0, 0, 0, "R4");
    acc(64'h1000_0010, 4'd0, 0, 0, 0, 0, "R4");
    acc(64'h0FFF_FFFF, 4'd1, 0, 0, 0, 0, "R4");
    acc(64'h0FFF_FFF8, 4'd7, 0, 0, 0, 0, "R4");
    acc(64'h1000_000C, 4'd15, 1, 0, 0, 0, "R4");
    // R11: idle cycle with matching address
    step(0, '0, '0, 0, 64'h1000_0000, 4'd0, 1, 0, 0, 0, "R11");
    // R2: unrelated register numbers
    wreg(10'hB6, 64'h0, "R2");
    wreg(10'hBE, 64'h0, "R2");
    wreg(10'h1B4, 64'h0, "R2");
    acc(64'h1000_0008, 4'd0, 1, 0, 0, 0, "R2");
    // R4: largest range
    wreg(10'hBC, rng(63) | C_ALL, "R4");
    acc(64'h1000_01FF, 4'd0, 0, 0, 0, 0, "R4");
    acc(64'h1000_0200, 4'd0, 0, 0, 0, 0, "R4");
    // R5: direction enables
    wreg(10'hBC, rng(0) | C_WR | C_XI | C_HV | C_SV | C_PR, "R5");
    acc(64'h1000_0000, 4'd3, 0, 0, 0, 0, "R5");
    acc(64'h1000_0000, 4'd3, 1, 0, 0, 0, "R5");
    wreg(10'hBC, rng(0) | C_XI | C_HV | C_SV | C_PR, "R5");
    acc(64'h1000_0000, 4'd3, 1, 0, 0, 0, "R5");
    acc(64'h1000_0000, 4'd3, 0, 1, 1, 1, "R5");
    // R6: translation compare
    wreg(10'hBC, rng(0) | C_RD | C_XV | C_HV | C_SV | C_PR, "R6");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 0, "R6");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 1, "R6");
    wreg(10'hBC, rng(0) | C_RD | C_HV | C_SV | C_PR, "R6");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 0, "R6");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 1, "R6");
    // R7: privilege enables
    wreg(10'hBC, rng(0) | C_RD | C_XI | C_PR, "R7");
    acc(64'h1000_0000, 4'd0, 0, 1, 0, 0, "R7");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 0, "R7");
    acc(64'h1000_0000, 4'd0, 0, 0, 1, 0, "R7");
    wreg(10'hBC, rng(0) | C_RD | C_XI | C_HV, "R7");
    acc(64'h1000_0000, 4'd0, 0, 0, 1, 0, "R7");
    acc(64'h1000_0000, 4'd0, 0, 1, 1, 0, "R7");
    wreg(10'hBC, rng(0) | C_RD | C_XI | C_SV, "R7");
    acc(64'h1000_0000, 4'd0, 0, 0, 0, 0, "R7");
    // R8: mirroring select has no effect
    wreg(10'hBC, rng(1) | C_ALL | C_MIR, "R8");
    acc(64'h1000_0008, 4'd0, 0, 0, 0, 0, "R8");
    acc(64'h1000_0010, 4'd0, 0, 0, 0, 0, "R8");
    acc(64'h1000_0000 ^ 64'h8000_0000_0000_0000, 4'd0, 0, 0, 0, 0, "R8");
    // R10: second channel, independent and overlapping
    wreg(10'hB5, 64'h2000, "R10");
    wreg(10'hBD, rng(0) | C_ALL, "R10");
    acc(64'h2004, 4'd1, 1, 0, 0, 0, "R10");
    acc(64'h1000_0000, 4'd0, 1, 0, 0, 0, "R10");
    wreg(10'hB5, 64'h1000_0008, "R10");
    acc(64'h1000_0008, 4'd0, 0, 1, 0, 0, "R10");
    acc(64'h1000_0000, 4'd0, 0, 1, 0, 0, "R10");
    step(0, '0, '0, 0, '0, '0, 0, 0, 0, 0, "R11");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule